// File: doc/BRIEF.md
# Coin and credit manager

This block keeps the credit count of an arcade I/O controller. It samples four active-low coin switches and four active-low button lines once per processing strobe. It turns fresh presses on the two coin slots and on the service switch into credits, and it takes credits away when a start button is pressed. Each slot has its own programmable coinage: a coins-per-credit nibble and a credits-per-coin nibble. A start-gate nibble lets the game decide when start buttons may spend credits.

After every strobe the block presents four result nibbles: the credit count in BCD as tens and units, the credit increment granted on that strobe, and the credit decrement taken on that strobe. A build-time option moves the increment/decrement pair in front of the BCD pair. Two further nibbles report the four button lines, each as its level together with a one-strobe pulse on a new press. All state changes on the strobe. The coinage nibbles load on a separate load strobe.

Top module: `coin_credit_mgr`

## Requirements
- R1: After reset, all six output nibbles are 0, the credit count is 0, and both slots have coins-per-credit = 1 and credits-per-coin = 1. So one coin on either slot then yields exactly one credit.
- R2: Switch inputs are active low. A line counts as a new press only when it is low at a strobe and was high at the previous strobe. A line held low across strobes gives no further credit, and a strobe with no coin line low reports an increment of 0.
- R3: A new press on coin bit 0 or coin bit 1 advances that slot's coin counter. When the count reaches the low three bits of the slot's coins-per-credit nibble, the increment is credits-per-coin minus bit 3 of coins-per-credit (0 if that difference is negative), and the threshold is removed from the counter.
- R4: If the threshold is not reached and bit 3 of the slot's coins-per-credit nibble is set, the increment is 1. If both slots assign an increment on the same strobe, slot 1's value is used.
- R5: A new press on coin bit 3 (service) sets the increment to 1, overriding both slots.
- R6: While debits are allowed, a new press on button bit 2 costs 1 credit if at least 1 is held. Button bit 3 costs 2 credits if at least 2 are held, and it is considered only on a strobe without a new press on bit 2. A debit that is not covered is not taken, and the decrement reports 0.
- R7: Debits are allowed only while the start-gate nibble is 0. Otherwise start buttons change neither the credit count nor the decrement.
- R8: The credit count saturates at CREDIT_MAX (99): additions beyond it are dropped, while the increment nibble still reports the granted value.
- R9: With SWAP_PAIRS = 0, nib0..nib3 carry tens, units, increment and decrement. With SWAP_PAIRS = 1 they carry increment, decrement, tens and units.
- R10: btn_lo = {level of bit 2, new press of bit 2, level of bit 0, new press of bit 0}. btn_hi = {level of bit 3, new press of bit 3, level of bit 1, new press of bit 1}. Levels are active-high here.
- R11: Outputs, the credit count, the coin counters and the edge history change only on a strobe. A switch change between strobes is judged against the value seen at the previous strobe. A coinage load takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle processing strobe |
| cfg_load | input | 1 | Loads the four coinage nibbles |
| cfg_ratio0 | input | 4 | Slot 0 coins-per-credit (bit 3 early credit) |
| cfg_mult0 | input | 4 | Slot 0 credits-per-coin |
| cfg_ratio1 | input | 4 | Slot 1 coins-per-credit (bit 3 early credit) |
| cfg_mult1 | input | 4 | Slot 1 credits-per-coin |
| start_gate | input | 4 | Debits allowed only when zero |
| coin_n | input | 4 | Active-low coin slot 0, slot 1, unused, service |
| btn_n | input | 4 | Active-low buttons; bits 2 and 3 are start buttons |
| nib0 | output | 4 | Result nibble 0 |
| nib1 | output | 4 | Result nibble 1 |
| nib2 | output | 4 | Result nibble 2 |
| nib3 | output | 4 | Result nibble 3 |
| btn_lo | output | 4 | Level and press pulse of buttons 0 and 2 |
| btn_hi | output | 4 | Level and press pulse of buttons 1 and 3 |

## Verification
On every clock, the assertions check that nothing moves without a strobe, that the count never passes its ceiling, and that the decrement stays in range. They also check that a strobe with the start gate closed, or with no credits held, takes nothing, and that a strobe with no coin line low grants nothing. The coinage arithmetic cannot be shown that way: the early-credit bit, the counter remainder, slot 1 overriding slot 0, the service override, the bit-2-before-bit-3 priority, saturation at 99 and the swapped nibble order all need the bench's press-and-release scenarios, which are compared against a model of the requirements.

// File: rtl/coin_credit_mgr.sv
module coin_credit_mgr #(
  parameter bit SWAP_PAIRS = 1'b0,
  parameter int CREDIT_MAX = 99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_load,
  input  logic [3:0] cfg_ratio0,
  input  logic [3:0] cfg_mult0,
  input  logic [3:0] cfg_ratio1,
  input  logic [3:0] cfg_mult1,
  input  logic [3:0] start_gate,
  input  logic [3:0] coin_n,
  input  logic [3:0] btn_n,
  output logic [3:0] nib0,
  output logic [3:0] nib1,
  output logic [3:0] nib2,
  output logic [3:0] nib3,
  output logic [3:0] btn_lo,
  output logic [3:0] btn_hi
);
  localparam int CW = $clog2(CREDIT_MAX + 1);
  localparam int SW = CW + 1;
  localparam logic [1:0] XS = SWAP_PAIRS ? 2'd2 : 2'd0;
  localparam logic [1:0] I_TENS = 2'd0 ^ XS;
  localparam logic [1:0] I_UNIT = 2'd1 ^ XS;
  localparam logic [1:0] I_INC  = 2'd2 ^ XS;
  localparam logic [1:0] I_DEC  = 2'd3 ^ XS;

  logic [3:0]    ratio_q [2];
  logic [3:0]    mult_q  [2];
  logic [2:0]    cnt_q   [2];
  logic [2:0]    cnt_d   [2];
  logic [3:0]    chist_q, bhist_q;
  logic [CW-1:0] cred_q, cred_d;
  logic [3:0]    out_q   [4];
  logic [3:0]    blo_q, bhi_q;
  logic [3:0]    add, sub, inc_w;
  logic [SW-1:0] sum;

  wire [3:0] cv    = ~coin_n;
  wire [3:0] bv    = ~btn_n;
  wire [3:0] cedge = cv & (cv ^ chist_q);
  wire [3:0] bedge = bv & (bv ^ bhist_q);

  always_comb begin
    add   = 4'd0;
    inc_w = 4'd0;
    for (int s = 0; s < 2; s++) begin
      cnt_d[s] = cnt_q[s];
      if (cedge[s]) begin
        inc_w = {1'b0, cnt_q[s]} + 4'd1;
        if (inc_w >= {1'b0, ratio_q[s][2:0]}) begin
          add = (mult_q[s] >= {3'b0, ratio_q[s][3]}) ? mult_q[s] - {3'b0, ratio_q[s][3]} : 4'd0;
          cnt_d[s] = 3'(inc_w - {1'b0, ratio_q[s][2:0]});
        end else begin
          cnt_d[s] = inc_w[2:0];
          if (ratio_q[s][3]) add = 4'd1;
        end
      end
    end
    if (cedge[3]) add = 4'd1;
    sub = 4'd0;
    if (start_gate == 4'd0) begin
      if (bedge[2]) begin
        if (cred_q >= CW'(1)) sub = 4'd1;
      end else if (bedge[3] && cred_q >= CW'(2)) begin
        sub = 4'd2;
      end
    end
    sum    = SW'(cred_q) + SW'(add) - SW'(sub);
    cred_d = (sum > SW'(CREDIT_MAX)) ? CW'(CREDIT_MAX) : sum[CW-1:0];
  end

  wire [CW-1:0] tens_w  = cred_d / CW'(10);
  wire [CW-1:0] units_w = cred_d % CW'(10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        ratio_q[s] <= 4'd1;
        mult_q[s]  <= 4'd1;
        cnt_q[s]   <= 3'd0;
      end
      for (int k = 0; k < 4; k++) out_q[k] <= 4'd0;
      chist_q <= 4'd0;
      bhist_q <= 4'd0;
      cred_q  <= '0;
      blo_q   <= 4'd0;
      bhi_q   <= 4'd0;
    end else begin
      if (cfg_load) begin
        ratio_q[0] <= cfg_ratio0;
        mult_q[0]  <= cfg_mult0;
        ratio_q[1] <= cfg_ratio1;
        mult_q[1]  <= cfg_mult1;
      end
      if (tick) begin
        cnt_q[0] <= cnt_d[0];
        cnt_q[1] <= cnt_d[1];
        chist_q  <= cv;
        bhist_q  <= bv;
        cred_q   <= cred_d;
        out_q[I_TENS] <= tens_w[3:0];
        out_q[I_UNIT] <= units_w[3:0];
        out_q[I_INC]  <= add;
        out_q[I_DEC]  <= sub;
        blo_q <= {bv[2], bedge[2], bv[0], bedge[0]};
        bhi_q <= {bv[3], bedge[3], bv[1], bedge[1]};
      end
    end
  end

  assign nib0   = out_q[0];
  assign nib1   = out_q[1];
  assign nib2   = out_q[2];
  assign nib3   = out_q[3];
  assign btn_lo = blo_q;
  assign btn_hi = bhi_q;

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cred_q) && $stable(nib0) && $stable(nib1) && $stable(nib2)
              && $stable(nib3) && $stable(btn_lo) && $stable(btn_hi));
  a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    cred_q <= CW'(CREDIT_MAX));
  a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    tick && start_gate != 4'd0 |=> out_q[I_DEC] == 4'd0);
  a_r6_no_overdraw: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cred_q == '0 |=> out_q[I_DEC] == 4'd0);
  a_r6_dec_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> out_q[I_DEC] <= 4'd2);
  a_r2_idle_coins: assert property (@(posedge clk) disable iff (!rst_n)
    tick && coin_n == 4'hF |=> out_q[I_INC] == 4'd0);
endmodule

// File: tb/test_coin_credit_mgr.sv
`timescale 1ns/1ps
module test_coin_credit_mgr;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cfg_load = 1'b0;
  logic [3:0] cfg_ratio0 = 4'd1, cfg_mult0 = 4'd1, cfg_ratio1 = 4'd1, cfg_mult1 = 4'd1;
  logic [3:0] start_gate = 4'd0, coin_n = 4'hF, btn_n = 4'hF;
  logic [3:0] nib0, nib1, nib2, nib3, btn_lo, btn_hi;
  logic [3:0] s0, s1, s2, s3, sblo, sbhi;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coin_credit_mgr i_coin_credit_mgr (.clk, .rst_n, .tick, .cfg_load, .cfg_ratio0, .cfg_mult0,
    .cfg_ratio1, .cfg_mult1, .start_gate, .coin_n, .btn_n, .nib0, .nib1, .nib2, .nib3,
    .btn_lo, .btn_hi);
  coin_credit_mgr #(.SWAP_PAIRS(1'b1)) i_swap (.clk, .rst_n, .tick, .cfg_load, .cfg_ratio0,
    .cfg_mult0, .cfg_ratio1, .cfg_mult1, .start_gate, .coin_n, .btn_n, .nib0(s0), .nib1(s1),
    .nib2(s2), .nib3(s3), .btn_lo(sblo), .btn_hi(sbhi));

  logic [23:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  int m_cred = 0;
  int m_cnt[2] = '{0, 0};
  int m_ratio[2] = '{1, 1};
  int m_mult[2] = '{1, 1};
  logic [3:0] m_ch = 4'd0, m_bh = 4'd0;

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      check(tag_q[0], {nib0, nib1, nib2, nib3, btn_lo, btn_hi}, exp_q[0]);
      void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  task automatic strobe(logic [3:0] c_n, logic [3:0] b_n, string tag);
    logic [3:0] cv, bv, ce, be;
    int add, sub, t;
    cv = ~c_n; bv = ~b_n;
    ce = cv & ~m_ch; be = bv & ~m_bh;
    add = 0;
    for (int s = 0; s < 2; s++)
      if (ce[s]) begin
        m_cnt[s]++;
        t = m_ratio[s] % 8;
        if (m_cnt[s] >= t) begin
          add = m_mult[s] - m_ratio[s] / 8;
          if (add < 0) add = 0;
          m_cnt[s] = (m_cnt[s] - t) % 8;
        end else if (m_ratio[s] >= 8) add = 1;
      end
    if (ce[3]) add = 1;
    sub = 0;
    if (start_gate == 0) begin
      if (be[2]) begin if (m_cred >= 1) sub = 1; end
      else if (be[3] && m_cred >= 2) sub = 2;
    end
    m_cred = m_cred + add - sub;
    if (m_cred > 99) m_cred = 99;
    m_ch = cv; m_bh = bv;
    @(negedge clk);
    coin_n = c_n; btn_n = b_n; tick = 1'b1;
    exp_q.push_back({4'(m_cred / 10), 4'(m_cred % 10), 4'(add), 4'(sub),
                     bv[2], be[2], bv[0], be[0], bv[3], be[3], bv[1], be[1]});
    due_q.push_back(cyc + 1);
    tag_q.push_back(tag);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic press(int coin_bit, int btn_bit, string tag);
    logic [3:0] c = 4'hF, b = 4'hF;
    if (coin_bit >= 0) c[coin_bit] = 1'b0;
    if (btn_bit >= 0) b[btn_bit] = 1'b0;
    strobe(c, b, tag);
    strobe(4'hF, 4'hF, tag);
  endtask

  task automatic load(int r0, int m0, int r1, int m1);
    @(negedge clk);
    cfg_ratio0 = 4'(r0); cfg_mult0 = 4'(m0); cfg_ratio1 = 4'(r1); cfg_mult1 = 4'(m1);
    cfg_load = 1'b1;
    m_ratio = '{r0, r1}; m_mult = '{m0, m1};
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic drain();
    while (due_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {nib0, nib1, nib2, nib3, btn_lo, btn_hi}, 24'h0);
    press(0, -1, "R1 default coinage one coin one credit");
    press(1, -1, "R1 default coinage slot1");
    strobe(4'hE, 4'hF, "R2 press");
    strobe(4'hE, 4'hF, "R2 held no credit");
    strobe(4'hE, 4'hF, "R2 held again");
    drain();
    snap = {nib0, nib1, nib2, nib3, btn_lo, btn_hi};
    coin_n = 4'hF; btn_n = 4'h0;
    repeat (3) @(negedge clk);
    check("R11 stable without strobe", {nib0, nib1, nib2, nib3, btn_lo, btn_hi}, snap);
    strobe(4'hE, 4'hF, "R11 edge judged against last strobe");
    strobe(4'hF, 4'hF, "R2 release");
    load(2, 1, 4'hA, 3);
    strobe(4'hF, 4'hF, "R11 load then idle");
    press(0, -1, "R3 first coin of two");
    press(0, -1, "R3 second coin pays");
    press(1, -1, "R4 early credit");
    press(1, -1, "R4 payout minus early bit");
    load(1, 2, 1, 3);
    strobe(4'hC, 4'hF, "R4 slot1 overrides slot0");
    strobe(4'hF, 4'hF, "R4 release");
    strobe(4'h4, 4'hF, "R5 service overrides slots");
    strobe(4'hF, 4'hF, "R5 release");
    press(3, -1, "R5 service alone");
    load(3, 4, 8, 0);
    press(1, -1, "R3 negative payout clamps");
    press(1, -1, "R4 early bit with zero threshold");
    press(-1, 2, "R6 one player start");
    strobe(4'hF, 4'h3, "R6 bit2 wins over bit3");
    strobe(4'hF, 4'hF, "R6 release");
    press(-1, 3, "R6 two player start");
    start_gate = 4'd1;
    press(-1, 2, "R7 gate closed bit2");
    press(-1, 3, "R7 gate closed bit3");
    start_gate = 4'd0;
    while (m_cred > 1) press(-1, 3, "R6 drain credits");
    press(-1, 3, "R6 bit3 needs two");
    press(-1, 2, "R6 last credit");
    press(-1, 2, "R6 no credit left");
    strobe(4'hF, 4'h5, "R10 buttons 1 and 3");
    strobe(4'hF, 4'hA, "R10 buttons 0 and 2 with release");
    strobe(4'hF, 4'hA, "R10 levels held");
    strobe(4'hF, 4'hF, "R10 release");
    load(1, 15, 1, 15);
    for (int k = 0; k < 8; k++) press(k % 2, -1, "R8 saturation at 99");
    drain();
    check("R9 swapped order", {s0, s1, s2, s3, sblo, sbhi},
          {nib2, nib3, nib0, nib1, btn_lo, btn_hi});
    check("R8 count held at 99", {16'h0, nib0, nib1}, {16'h0, 4'd9, 4'd9});
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule